// File: doc/BRIEF.md
# Frame Destination Address Lookup Engine

This block decides whether an incoming frame is addressed to the local station. A frame parser, which lies outside the block, presents three things: the kind of destination address, the address value and a one-cycle start pulse. A short node address is compared at once with a node identity input. A 16-bit selector or a 32-bit link selector is looked up in a table. Software builds that table in external memory, and the block walks it one entry at a time through a byte-wide read port.

Each search ends in one of three ways: a hit, a miss, or, for node addresses, a broadcast. The outcome is held in a 4-bit status word. On a hit, the block also captures a match vector. An interrupt line merges the status bits under a master enable.

Both tables share one segment value, which forms the upper byte of every memory address. Each table has its own 16-bit start pointer. The end of a table is marked by a run of consecutive all-zero entries.

Top module: `atl_lookup`

## Requirements
- R1: After reset, `status` is 0, `match_vec` is 0, `mem_req` is 0 and `irq` is 0.
- R2: A start with `lookup_kind` 0 (node) compares `lookup_addr[7:0]` with `node_id`, and after the start edge sets status bit 1 (hit) if they are equal or status bit 2 (miss) if they are not. No memory is read.
- R3: A node address equal to the broadcast value 0xFF sets only status bit 0 (broadcast). This takes priority over the `node_id` comparison.
- R4: A start with kind 1 (selector) reads 2-byte entries from `mem_addr = {tbl_seg, sel_base + offset}`, most significant byte first. Only `lookup_addr[15:0]` is compared.
- R5: A start with kind 2 (link selector) reads 4-byte entries from `link_base` in the same way and compares all 32 bits of `lookup_addr`.
- R6: On a table hit, status bit 1 is set and `match_vec` takes the 16-bit address of the first byte after the matching entry.
- R7: An all-zero entry never matches. Three zero entries in a row end the search with status bit 2. A nonzero entry restarts the zero count, and hit and miss are never set together.
- R8: A miss of any kind leaves `match_vec` at its previous value.
- R9: `mem_req` stays high with a stable address until `mem_valid` is seen. Each `mem_valid` consumes exactly one byte, and the address then advances by one.
- R10: A new accepted start abandons any search in progress. The result reflects only the new request.
- R11: While `recog_en` is 0, or when `lookup_kind` is 3, a start pulse is ignored: the status and `match_vec` are unchanged and no read is issued.
- R12: A pulse on `fc_seen` sets status bit 3. An accepted start clears all status bits except one set by `fc_seen` in the same cycle.
- R13: `irq` is high exactly when `irq_en` is 1 and some status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| recog_en | input | 1 | Address recognition enable |
| irq_en | input | 1 | Master interrupt enable |
| node_id | input | 8 | Local node identity |
| sel_base | input | 16 | Selector table start pointer |
| link_base | input | 16 | Link selector table start pointer |
| tbl_seg | input | 8 | Segment shared by both tables |
| lookup_go | input | 1 | One-cycle start pulse |
| lookup_kind | input | 2 | 0 node, 1 selector, 2 link selector, 3 ignored |
| lookup_addr | input | 32 | Destination address value |
| fc_seen | input | 1 | Frame control byte detected pulse |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 24 | Memory read address {segment, pointer} |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data byte |
| status | output | 4 | Bit0 broadcast, bit1 hit, bit2 miss, bit3 frame control |
| match_vec | output | 16 | Address after the matching entry |
| irq | output | 1 | Interrupt request |

## Verification
A node result is registered on the start edge itself, so the bench samples it at the falling edge that follows, with no extra wait. A table result depends on the memory response. With a memory that answers every request on the next falling edge, each entry takes exactly 2·W clock edges, where W is the entry width in bytes, so a result after N entries appears 2·W·N edges after the start edge. The bench counts edges from the start edge and compares that count exactly for every table vector. A slower memory, with an added latency L, stretches each byte to L+2 edges; a directed case checks that this gives N·W·(L+2) edges.

// File: rtl/atl_pkg.sv
package atl_pkg;
   typedef enum logic [1:0] {
      ATL_NODE = 2'd0,
      ATL_SEL  = 2'd1,
      ATL_LINK = 2'd2,
      ATL_RSVD = 2'd3
   } atl_kind_e;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_READ  = 2'd1,
      SQ_CHECK = 2'd2
   } atl_seq_e;

   localparam int ST_BCAST = 0;
   localparam int ST_HIT   = 1;
   localparam int ST_MISS  = 2;
   localparam int ST_FC    = 3;
   localparam int ST_W     = 4;
endpackage

// File: rtl/atl_fetch.sv
module atl_fetch #(
   parameter int SEG_W = 8,
   parameter int PTR_W = 16,
   localparam int ADDR_W = SEG_W + PTR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              abort,
   input  logic [PTR_W-1:0]  load_ptr,
   input  logic [SEG_W-1:0]  seg,
   input  logic              rd_en,
   input  logic              mem_valid,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              take,
   output logic [PTR_W-1:0]  ptr
);
   logic [PTR_W-1:0] ptr_q;

   assign take     = rd_en & mem_valid & ~abort;
   assign mem_req  = rd_en;
   assign mem_addr = {seg, ptr_q};
   assign ptr      = ptr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (load) begin
         ptr_q <= load_ptr;
      end else if (take) begin
         ptr_q <= ptr_q + PTR_W'(1);
      end
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_valid && !abort) |=> (mem_req && $stable(ptr_q))); // R9
endmodule

// File: rtl/atl_entry.sv
module atl_entry #(
   parameter int MAX_BYTES = 4,
   parameter int SEL_BYTES = 2,
   localparam int VAL_W = 8 * MAX_BYTES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             take,
   input  logic [7:0]       byte_in,
   input  logic             wide,
   input  logic [VAL_W-1:0] target,
   output logic             is_zero,
   output logic             is_hit
);
   logic [VAL_W-1:0]     shreg_q;
   logic [MAX_BYTES-1:0] lane_used;
   logic [MAX_BYTES-1:0] lane_eq;
   logic [MAX_BYTES-1:0] lane_nz;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg_q <= '0;
      end else if (clear) begin
         shreg_q <= '0;
      end else if (take) begin
         shreg_q <= {shreg_q[VAL_W-9:0], byte_in};
      end
   end

   for (genvar l = 0; l < MAX_BYTES; l++) begin : g_lane
      if (l < SEL_BYTES) begin : g_narrow
         assign lane_used[l] = 1'b1;
      end else begin : g_wide
         assign lane_used[l] = wide;
      end
      assign lane_eq[l] = (shreg_q[8*l +: 8] == target[8*l +: 8]);
      assign lane_nz[l] = lane_used[l] && (shreg_q[8*l +: 8] != 8'h00);
   end

   assign is_zero = ~|lane_nz;
   assign is_hit  = (&(lane_eq | ~lane_used)) & ~is_zero;
endmodule

// File: rtl/atl_seq.sv
module atl_seq
   import atl_pkg::*;
#(
   parameter int MAX_BYTES = 4,
   parameter int SEL_BYTES = 2,
   parameter int RUN       = 3,
   localparam int CNT_W = $clog2(MAX_BYTES) + 1,
   localparam int ZW    = $clog2(RUN + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go_any,
   input  logic go_tbl,
   input  logic wide,
   input  logic take,
   input  logic is_zero,
   input  logic is_hit,
   output logic rd_en,
   output logic clr_entry,
   output logic found,
   output logic exhausted
);
   atl_seq_e         state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [ZW-1:0]    zrun_q;
   logic [CNT_W-1:0] last_idx;
   logic             run_full;

   assign last_idx  = wide ? CNT_W'(MAX_BYTES - 1) : CNT_W'(SEL_BYTES - 1);
   assign run_full  = (zrun_q == ZW'(RUN - 1));
   assign rd_en     = (state_q == SQ_READ);
   assign clr_entry = (state_q == SQ_CHECK) | go_any;
   assign found     = (state_q == SQ_CHECK) & is_hit & ~go_any;
   assign exhausted = (state_q == SQ_CHECK) & ~is_hit & is_zero & run_full & ~go_any;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         cnt_q   <= '0;
         zrun_q  <= '0;
      end else if (go_any) begin
         state_q <= go_tbl ? SQ_READ : SQ_IDLE;
         cnt_q   <= '0;
         zrun_q  <= '0;
      end else begin
         case (state_q)
            SQ_READ: begin
               if (take) begin
                  if (cnt_q == last_idx) begin
                     cnt_q   <= '0;
                     state_q <= SQ_CHECK;
                  end else begin
                     cnt_q <= cnt_q + CNT_W'(1);
                  end
               end
            end
            SQ_CHECK: begin
               if (is_hit) begin
                  state_q <= SQ_IDLE;
               end else if (is_zero) begin
                  if (run_full) begin
                     state_q <= SQ_IDLE;
                  end else begin
                     zrun_q  <= zrun_q + ZW'(1);
                     state_q <= SQ_READ;
                  end
               end else begin
                  zrun_q  <= '0;
                  state_q <= SQ_READ;
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   AST_SEQ_NO_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (found || exhausted) |=> !rd_en || $past(go_any)); // R7
endmodule

// File: rtl/atl_lookup.sv
module atl_lookup
   import atl_pkg::*;
#(
   parameter int NODE_W       = 8,
   parameter int SEG_W        = 8,
   parameter int PTR_W        = 16,
   parameter int SEL_BYTES    = 2,
   parameter int LINK_BYTES   = 4,
   parameter int SENTINEL_RUN = 3,
   parameter logic [NODE_W-1:0] BCAST_ID = '1,
   localparam int VAL_W  = 8 * LINK_BYTES,
   localparam int ADDR_W = SEG_W + PTR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              recog_en,
   input  logic              irq_en,
   input  logic [NODE_W-1:0] node_id,
   input  logic [PTR_W-1:0]  sel_base,
   input  logic [PTR_W-1:0]  link_base,
   input  logic [SEG_W-1:0]  tbl_seg,
   input  logic              lookup_go,
   input  logic [1:0]        lookup_kind,
   input  logic [VAL_W-1:0]  lookup_addr,
   input  logic              fc_seen,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_valid,
   input  logic [7:0]        mem_rdata,
   output logic [ST_W-1:0]   status,
   output logic [PTR_W-1:0]  match_vec,
   output logic              irq
);
   if (SEL_BYTES < 1 || SEL_BYTES > LINK_BYTES) begin : g_chk_sel
      $error("SEL_BYTES must lie in 1..LINK_BYTES");
   end
   if (LINK_BYTES < 2) begin : g_chk_link
      $error("LINK_BYTES must be at least 2");
   end
   if (SENTINEL_RUN < 1) begin : g_chk_run
      $error("SENTINEL_RUN must be at least 1");
   end
   if (NODE_W > VAL_W) begin : g_chk_node
      $error("NODE_W must not exceed the link entry width");
   end

   atl_kind_e        kind;
   logic             go_any, go_tbl, go_node;
   logic             wide_q;
   logic [VAL_W-1:0] target_q;
   logic [PTR_W-1:0] base_sel;
   logic [PTR_W-1:0] ptr;
   logic             take, rd_en, clr_entry, found, exhausted;
   logic             is_zero, is_hit;
   logic             node_bc, node_eq;
   logic [ST_W-1:0]  status_q;
   logic [PTR_W-1:0] match_vec_q;

   assign kind     = atl_kind_e'(lookup_kind);
   assign go_any   = lookup_go & recog_en & (kind != ATL_RSVD);
   assign go_tbl   = go_any & ((kind == ATL_SEL) | (kind == ATL_LINK));
   assign go_node  = go_any & (kind == ATL_NODE);
   assign base_sel = (kind == ATL_LINK) ? link_base : sel_base;
   assign node_bc  = (lookup_addr[NODE_W-1:0] == BCAST_ID);
   assign node_eq  = (lookup_addr[NODE_W-1:0] == node_id);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         target_q <= '0;
         wide_q   <= 1'b0;
      end else if (go_tbl) begin
         target_q <= lookup_addr;
         wide_q   <= (kind == ATL_LINK);
      end
   end

   atl_fetch #(.SEG_W(SEG_W), .PTR_W(PTR_W)) u_fetch (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (go_tbl),
      .abort    (go_any),
      .load_ptr (base_sel),
      .seg      (tbl_seg),
      .rd_en    (rd_en),
      .mem_valid(mem_valid),
      .mem_req  (mem_req),
      .mem_addr (mem_addr),
      .take     (take),
      .ptr      (ptr)
   );

   atl_entry #(.MAX_BYTES(LINK_BYTES), .SEL_BYTES(SEL_BYTES)) u_entry (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (clr_entry),
      .take   (take),
      .byte_in(mem_rdata),
      .wide   (wide_q),
      .target (target_q),
      .is_zero(is_zero),
      .is_hit (is_hit)
   );

   atl_seq #(.MAX_BYTES(LINK_BYTES), .SEL_BYTES(SEL_BYTES), .RUN(SENTINEL_RUN)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .go_any   (go_any),
      .go_tbl   (go_tbl),
      .wide     (wide_q),
      .take     (take),
      .is_zero  (is_zero),
      .is_hit   (is_hit),
      .rd_en    (rd_en),
      .clr_entry(clr_entry),
      .found    (found),
      .exhausted(exhausted)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q    <= '0;
         match_vec_q <= '0;
      end else begin
         if (go_any) begin
            status_q <= '0;
            if (go_node) begin
               if (node_bc) begin
                  status_q[ST_BCAST] <= 1'b1;
               end else if (node_eq) begin
                  status_q[ST_HIT] <= 1'b1;
               end else begin
                  status_q[ST_MISS] <= 1'b1;
               end
            end
         end else begin
            if (found) begin
               status_q[ST_HIT] <= 1'b1;
               match_vec_q      <= ptr;
            end
            if (exhausted) begin
               status_q[ST_MISS] <= 1'b1;
            end
         end
         if (fc_seen) begin
            status_q[ST_FC] <= 1'b1;
         end
      end
   end

   assign status    = status_q;
   assign match_vec = match_vec_q;
   assign irq       = irq_en & (|status_q);

   AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      !(status[ST_HIT] && status[ST_MISS])); // R7
   AST_VEC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[ST_MISS]) |-> $stable(match_vec)); // R8
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_valid && !lookup_go) |=>
      (!mem_req || mem_addr[PTR_W-1:0] == $past(mem_addr[PTR_W-1:0]) + PTR_W'(1))); // R4
   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (lookup_go && recog_en && (lookup_kind == 2'd1 || lookup_kind == 2'd2) && !fc_seen)
      |=> (status == '0)); // R12
endmodule

// File: tb/test_atl_lookup.sv
module test_atl_lookup;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        recog_en = 1'b0;
   logic        irq_en = 1'b0;
   logic [7:0]  node_id = 8'h5A;
   logic [15:0] sel_base = 16'h0010;
   logic [15:0] link_base = 16'h0080;
   logic [7:0]  tbl_seg = 8'h3C;
   logic        lookup_go = 1'b0;
   logic [1:0]  lookup_kind = 2'd0;
   logic [31:0] lookup_addr = '0;
   logic        fc_seen = 1'b0;
   logic        mem_req;
   logic [23:0] mem_addr;
   logic        mem_valid = 1'b0;
   logic [7:0]  mem_rdata = '0;
   logic [3:0]  status;
   logic [15:0] match_vec;
   logic        irq;

   logic [7:0]  mem [256];
   int          lat = 0;
   int          wcnt = 0;
   int          seg_err = 0;
   int          n_chk = 0;
   int          n_fail = 0;

   always #4 clk = ~clk;

   atl_lookup i_atl_lookup (
      .clk(clk), .rst_n(rst_n), .recog_en(recog_en), .irq_en(irq_en),
      .node_id(node_id), .sel_base(sel_base), .link_base(link_base),
      .tbl_seg(tbl_seg), .lookup_go(lookup_go), .lookup_kind(lookup_kind),
      .lookup_addr(lookup_addr), .fc_seen(fc_seen), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
      .status(status), .match_vec(match_vec), .irq(irq)
   );

   // Memory model: answers a held request after lat extra falling edges.
   always @(negedge clk) begin
      if (!rst_n || !mem_req) begin
         mem_valid = 1'b0;
         wcnt = 0;
      end else if (mem_valid) begin
         mem_valid = 1'b0;
      end else if (wcnt == lat) begin
         mem_valid = 1'b1;
         wcnt = 0;
      end else begin
         wcnt = wcnt + 1;
      end
      mem_rdata = mem[mem_addr[7:0]];
      if (mem_req && mem_addr[23:16] != tbl_seg) seg_err = seg_err + 1;
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic put16(input int a, input logic [15:0] v);
      mem[a] = v[15:8]; mem[a+1] = v[7:0];
   endtask

   task automatic put32(input int a, input logic [31:0] v);
      mem[a] = v[31:24]; mem[a+1] = v[23:16]; mem[a+2] = v[15:8]; mem[a+3] = v[7:0];
   endtask

   task automatic pulse_go(input logic [1:0] k, input logic [31:0] a);
      @(negedge clk);
      lookup_go = 1'b1; lookup_kind = k; lookup_addr = a;
      @(posedge clk);
      @(negedge clk);
      lookup_go = 1'b0;
   endtask

   task automatic run_lookup(input logic [1:0] k, input logic [31:0] a, output int cyc);
      pulse_go(k, a);
      cyc = 0;
      while (status[2:0] == 3'b000 && cyc < 2000) begin
         @(posedge clk);
         @(negedge clk);
         cyc++;
      end
   endtask

   // kind, address, expected status, expected match vector, expected edge count
   localparam logic [69:0] VEC [12] = '{
      {2'd0, 32'h0000005A, 4'b0010, 16'h0000, 16'd0},
      {2'd0, 32'h00000033, 4'b0100, 16'h0000, 16'd0},
      {2'd0, 32'h000000FF, 4'b0001, 16'h0000, 16'd0},
      {2'd1, 32'h00001234, 4'b0010, 16'h0012, 16'd4},
      {2'd1, 32'h0000ABCD, 4'b0010, 16'h0016, 16'd12},
      {2'd1, 32'h00000055, 4'b0010, 16'h0018, 16'd16},
      {2'd1, 32'h00007777, 4'b0100, 16'h0018, 16'd28},
      {2'd2, 32'h11223344, 4'b0010, 16'h0084, 16'd8},
      {2'd2, 32'hCAFEF00D, 4'b0010, 16'h0090, 16'd32},
      {2'd2, 32'h00003344, 4'b0100, 16'h0090, 16'd56},
      {2'd1, 32'h00000000, 4'b0100, 16'h0090, 16'd28},
      {2'd1, 32'hFFFF1234, 4'b0010, 16'h0012, 16'd4}
   };

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      int cyc;
      string tag;
      logic [3:0] st_prev;
      logic [15:0] vec_prev;
      int req_seen;

      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      put16(16'h10, 16'h1234); put16(16'h12, 16'h0000); put16(16'h14, 16'hABCD);
      put16(16'h16, 16'h0055);
      put32(16'h80, 32'h11223344); put32(16'h8C, 32'hCAFEF00D);

      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 status", 64'(status), 64'h0);
      chk("R1 match_vec", 64'(match_vec), 64'h0);
      chk("R1 mem_req", 64'(mem_req), 64'h0);
      chk("R1 irq", 64'(irq), 64'h0);
      rst_n = 1'b1;
      recog_en = 1'b1;

      for (int v = 0; v < 12; v++) begin
         case (VEC[v][69:68])
            2'd0:    tag = "R2_R3";
            2'd1:    tag = "R4_R6_R7";
            default: tag = "R5_R6_R7";
         endcase
         run_lookup(VEC[v][69:68], VEC[v][67:36], cyc);
         chk($sformatf("%s status v%0d", tag, v), 64'(status), 64'(VEC[v][35:32]));
         chk($sformatf("R6_R8 match_vec v%0d", v), 64'(match_vec), 64'(VEC[v][31:16]));
         chk($sformatf("R9 edges v%0d", v), 64'(cyc), 64'(VEC[v][15:0]));
         repeat (2) @(negedge clk);
      end
      chk("R4 segment on mem_addr", 64'(seg_err), 64'h0);

      // R12: frame control pulse sets bit 3, accepted start clears it
      st_prev = status;
      @(negedge clk); fc_seen = 1'b1;
      @(negedge clk); fc_seen = 1'b0;
      chk("R12 fc sets bit3", 64'(status), 64'(st_prev | 4'b1000));
      run_lookup(2'd1, 32'h00001234, cyc);
      chk("R12 start clears bit3", 64'(status), 64'h2);

      // R13: interrupt follows master enable and status
      chk("R13 irq masked", 64'(irq), 64'h0);
      @(negedge clk); irq_en = 1'b1;
      @(negedge clk);
      chk("R13 irq raised", 64'(irq), 64'h1);
      irq_en = 1'b0;
      @(negedge clk);
      chk("R13 irq dropped", 64'(irq), 64'h0);

      // R11: starts ignored while disabled or with the unused kind
      st_prev = status; vec_prev = match_vec; req_seen = 0;
      recog_en = 1'b0;
      pulse_go(2'd1, 32'h0000ABCD);
      for (int c = 0; c < 20; c++) begin
         @(negedge clk);
         if (mem_req) req_seen++;
      end
      recog_en = 1'b1;
      pulse_go(2'd3, 32'h0000ABCD);
      for (int c = 0; c < 20; c++) begin
         @(negedge clk);
         if (mem_req) req_seen++;
      end
      chk("R11 no reads", 64'(req_seen), 64'h0);
      chk("R11 status kept", 64'(status), 64'(st_prev));
      chk("R11 match_vec kept", 64'(match_vec), 64'(vec_prev));

      // R10: a new start abandons the running link search
      pulse_go(2'd2, 32'hCAFEF00D);
      repeat (10) @(negedge clk);
      run_lookup(2'd1, 32'h0000ABCD, cyc);
      chk("R10 abort status", 64'(status), 64'h2);
      chk("R10 abort match_vec", 64'(match_vec), 64'h0016);
      repeat (5) @(negedge clk);
      chk("R10 abort no late result", 64'(match_vec), 64'h0016);

      // R9: slow memory, each byte waits for valid
      lat = 2;
      run_lookup(2'd1, 32'h00000055, cyc);
      chk("R9 slow status", 64'(status), 64'h2);
      chk("R9 slow match_vec", 64'(match_vec), 64'h0018);
      chk("R9 slow edges", 64'(cyc), 64'd32);
      lat = 0;

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule